// File: doc/BRIEF.md
# Reset and Stop-Recovery Delay Sequencer

This block times the start-up and wake-up delays of a small controller from one shared 13-bit counter, which advances on every falling edge of the oscillator clock. When power comes up, or when an internal reset source fires (the low-voltage detector), the block pulls the external reset pin low for a fixed count. It then keeps the CPU in reset for a short further stretch before letting it run.

The same counter times the return from stop mode. A stop request clears the counter and gates off the bus clocks. A wake event starts a recovery delay whose length is chosen by an option bit: short for canned oscillators, long for crystals. The bus clocks come back on the edge where that delay completes.

In normal running the counter free-runs, and each wrap from all-ones to zero yields a one-cycle prescaled tick for a watchdog. An external reset seen on the pin reaches the CPU reset output but leaves the counter untouched, so the watchdog cadence continues across it.

Top module: `rsq_top`

## Requirements
- R1: While the counter free-runs, `wdog_tick` is a one-cycle pulse that recurs every 8192 falling edges. The pulse is observed in the cycle after the counter wraps from 8191 to 0.
- R2: `por` is a synchronous active-high reset sampled on the falling edge. It clears the counter and `lvd_flag`, and it starts the internal reset sequence. While `por` is high, `pin_drive_low=1`, `cpu_rst=1`, `bus_clk_en=1`, `lvd_flag=0` and `wdog_tick=0`.
- R3: `pin_drive_low` falls on the 4096th falling edge after the edge that starts the reset sequence.
- R4: `cpu_rst` stays high for 64 more falling edges after `pin_drive_low` falls, so it drops on the 4160th edge. `pin_drive_low=1` always implies `cpu_rst=1`.
- R5: `lvd_det` high on an edge clears the counter, sets `lvd_flag`, and restarts the reset sequence. While `lvd_det` stays high the sequence is held at its start, and R3 counts from the last edge on which it was high.
- R6: `lvd_flag` holds its value until `flag_clr` is high on an edge. If `lvd_det` and `flag_clr` are high on the same edge, the flag is set.
- R7: `stop_req` during normal running clears the counter and drops `bus_clk_en`. The counter is held at zero while stopped. `stop_req` has no effect during the reset sequence or during recovery.
- R8: A `wake_evt` while stopped starts recovery, and `short_wake` is sampled on that edge. `bus_clk_en` rises on the 32nd falling edge after the wake edge when `short_wake=1`, and on the 4096th edge when `short_wake=0`.
- R9: `ext_rst_n=0` forces `cpu_rst=1` at once. It changes neither the counter nor the timing of `wdog_tick`.
- R10: When a stop clear lands on the same edge as a counter wrap, the clear wins and no `wdog_tick` is produced.
- R11: `lvd_det` while stopped or recovering takes priority over `wake_evt` and starts the reset sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator clock; all state changes on its falling edge |
| por | input | 1 | Power-on reset, synchronous, active high |
| lvd_det | input | 1 | Low-voltage detect, an internal reset source |
| ext_rst_n | input | 1 | External reset seen on the pin, active low |
| stop_req | input | 1 | Stop mode request |
| wake_evt | input | 1 | Interrupt or break wake event |
| short_wake | input | 1 | Recovery option: 1 selects 32 cycles, 0 selects 4096 |
| flag_clr | input | 1 | Clears the low-voltage status flag |
| pin_drive_low | output | 1 | Drive the external reset pin low |
| cpu_rst | output | 1 | CPU reset, active high |
| bus_clk_en | output | 1 | Enable for the bus clocks |
| lvd_flag | output | 1 | Low-voltage reset status flag |
| wdog_tick | output | 1 | Prescaled tick for the watchdog |

## Verification
The counter's wrap into zero and the clear caused by a stop request can fall on the same falling edge. When that happens, the tick and the cleared count compete for the same edge. The bench provokes this by waiting until its reference count reads 8191 during normal running, then asserting `stop_req` for exactly the next edge. The check is that `wdog_tick` stays low while `bus_clk_en` drops. A second collision, a low-voltage event arriving together with a wake while stopped, is judged by the pin drive rising and the recovery never completing.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

    typedef enum logic [2:0] {
        PH_PIN_HOLD = 3'd0,
        PH_CPU_HOLD = 3'd1,
        PH_RUN      = 3'd2,
        PH_STOPPED  = 3'd3,
        PH_RECOVER  = 3'd4
    } phase_e;

    typedef struct packed {
        logic pin_low;
        logic cpu_hold;
        logic bus_en;
    } seq_out_t;

    function automatic seq_out_t decode_phase(phase_e ph);
        seq_out_t o;
        o.pin_low  = (ph == PH_PIN_HOLD);
        o.cpu_hold = (ph == PH_PIN_HOLD) || (ph == PH_CPU_HOLD);
        o.bus_en   = !((ph == PH_STOPPED) || (ph == PH_RECOVER));
        return o;
    endfunction

endpackage

// File: rtl/rsq_counter.sv
module rsq_counter #(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             hold,
    output logic [CNT_W-1:0] cnt_o,
    output logic             tick_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(negedge clk) begin
        if (clr || hold) begin
            cnt_o  <= '0;
            tick_o <= 1'b0;
        end else begin
            cnt_o  <= cnt_o + 1'b1;
            tick_o <= (cnt_o == CNT_MAX);
        end
    end

    // R1: a tick is only ever seen when the count has just wrapped to zero
    assert_tick_at_zero_R1: assert property (@(negedge clk) disable iff (clr)
        tick_o |-> (cnt_o == '0));

endmodule

// File: rtl/rsq_phase_fsm.sv
module rsq_phase_fsm
    import rsq_pkg::*;
#(
    parameter int CNT_W     = 13,
    parameter int PIN_CYC   = 4096,
    parameter int CPU_CYC   = 64,
    parameter int SHORT_CYC = 32,
    parameter int LONG_CYC  = 4096
) (
    input  logic             clk,
    input  logic             por,
    input  logic             lvd_det,
    input  logic             stop_req,
    input  logic             wake_evt,
    input  logic             short_wake,
    input  logic [CNT_W-1:0] cnt_i,
    output phase_e           phase_o,
    output logic             cnt_clr_o,
    output logic             cnt_hold_o
);
    localparam logic [CNT_W-1:0] PIN_LAST   = CNT_W'(PIN_CYC - 1);
    localparam logic [CNT_W-1:0] CPU_LAST   = CNT_W'(PIN_CYC + CPU_CYC - 1);
    localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_CYC - 1);
    localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_CYC - 1);

    phase_e phase_q, phase_d;
    logic   short_q;
    logic   [CNT_W-1:0] wake_last;

    assign wake_last  = short_q ? SHORT_LAST : LONG_LAST;
    assign cnt_clr_o  = lvd_det || ((phase_q == PH_RUN) && stop_req);
    assign cnt_hold_o = (phase_q == PH_STOPPED);
    assign phase_o    = phase_q;

    always_comb begin
        phase_d = phase_q;
        if (lvd_det) begin
            phase_d = PH_PIN_HOLD;
        end else begin
            case (phase_q)
                PH_PIN_HOLD: if (cnt_i == PIN_LAST)  phase_d = PH_CPU_HOLD;
                PH_CPU_HOLD: if (cnt_i == CPU_LAST)  phase_d = PH_RUN;
                PH_RUN:      if (stop_req)           phase_d = PH_STOPPED;
                PH_STOPPED:  if (wake_evt)           phase_d = PH_RECOVER;
                PH_RECOVER:  if (cnt_i == wake_last) phase_d = PH_RUN;
                default:                             phase_d = PH_PIN_HOLD;
            endcase
        end
    end

    always_ff @(negedge clk) begin
        if (por) begin
            phase_q <= PH_PIN_HOLD;
            short_q <= 1'b0;
        end else begin
            phase_q <= phase_d;
            if ((phase_q == PH_STOPPED) && wake_evt && !lvd_det)
                short_q <= short_wake;
        end
    end

    // R11: low-voltage detect during stop beats a simultaneous wake
    assert_lvd_beats_wake_R11: assert property (@(negedge clk) disable iff (por)
        ((phase_q == PH_STOPPED) && lvd_det && wake_evt) |=> (phase_q == PH_PIN_HOLD));

    // R7: a stop entered from normal running leaves the counter at zero
    assert_stop_clears_R7: assert property (@(negedge clk) disable iff (por)
        ((phase_q == PH_RUN) && stop_req && !lvd_det) |=> ((cnt_i == '0) && (phase_q == PH_STOPPED)));

endmodule

// File: rtl/rsq_status.sv
module rsq_status (
    input  logic clk,
    input  logic por,
    input  logic lvd_det,
    input  logic flag_clr,
    output logic lvd_flag_o
);
    always_ff @(negedge clk) begin
        if (por)           lvd_flag_o <= 1'b0;
        else if (lvd_det)  lvd_flag_o <= 1'b1;
        else if (flag_clr) lvd_flag_o <= 1'b0;
    end

    // R6: a clear request without a new event empties the flag
    assert_flag_clear_R6: assert property (@(negedge clk) disable iff (por)
        (flag_clr && !lvd_det) |=> !lvd_flag_o);

    // R5: a low-voltage event always leaves the flag set
    assert_flag_set_R5: assert property (@(negedge clk) disable iff (por)
        lvd_det |=> lvd_flag_o);

endmodule

// File: rtl/rsq_top.sv
module rsq_top
    import rsq_pkg::*;
#(
    parameter int CNT_W     = 13,
    parameter int PIN_CYC   = 4096,
    parameter int CPU_CYC   = 64,
    parameter int SHORT_CYC = 32,
    parameter int LONG_CYC  = 4096
) (
    input  logic osc_clk,
    input  logic por,
    input  logic lvd_det,
    input  logic ext_rst_n,
    input  logic stop_req,
    input  logic wake_evt,
    input  logic short_wake,
    input  logic flag_clr,
    output logic pin_drive_low,
    output logic cpu_rst,
    output logic bus_clk_en,
    output logic lvd_flag,
    output logic wdog_tick
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt;
    logic             seq_clr, seq_hold;
    phase_e           phase;
    seq_out_t         dec;

    rsq_counter #(.CNT_W(CNT_W)) i_cnt (
        .clk    (osc_clk),
        .clr    (por || seq_clr),
        .hold   (seq_hold),
        .cnt_o  (cnt),
        .tick_o (wdog_tick)
    );

    rsq_phase_fsm #(
        .CNT_W(CNT_W), .PIN_CYC(PIN_CYC), .CPU_CYC(CPU_CYC),
        .SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)
    ) i_fsm (
        .clk        (osc_clk),
        .por        (por),
        .lvd_det    (lvd_det),
        .stop_req   (stop_req),
        .wake_evt   (wake_evt),
        .short_wake (short_wake),
        .cnt_i      (cnt),
        .phase_o    (phase),
        .cnt_clr_o  (seq_clr),
        .cnt_hold_o (seq_hold)
    );

    rsq_status i_stat (
        .clk        (osc_clk),
        .por        (por),
        .lvd_det    (lvd_det),
        .flag_clr   (flag_clr),
        .lvd_flag_o (lvd_flag)
    );

    assign dec           = decode_phase(phase);
    assign pin_drive_low = dec.pin_low;
    assign cpu_rst       = dec.cpu_hold || !ext_rst_n;
    assign bus_clk_en    = dec.bus_en;

    // R4: the pin is never driven low without the CPU also held
    assert_pin_implies_cpu_R4: assert property (@(negedge osc_clk) disable iff (por)
        pin_drive_low |-> cpu_rst);

    // R10: a stop clear on the wrap edge suppresses the tick
    assert_clear_beats_tick_R10: assert property (@(negedge osc_clk) disable iff (por)
        (bus_clk_en && !cpu_rst && stop_req && !lvd_det && (cnt == CNT_MAX)) |=> !wdog_tick);

    // R5: low-voltage detect drives the reset pin on the next cycle
    assert_lvd_pin_R5: assert property (@(negedge osc_clk) disable iff (por)
        lvd_det |=> pin_drive_low);

endmodule

// File: tb/test_rsq_top.sv
module test_rsq_top;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic por = 1'b1, lvd = 1'b0, ext_n = 1'b1, stop = 1'b0, wake = 1'b0, shrt = 1'b0, fclr = 1'b0;
    logic pin, cpu, bus, flag, tick;
    int   total = 0, bad = 0;
    bit   started = 1'b0, done = 1'b0;

    // reference model state
    int m_cnt = 0, m_ph = 0;
    bit m_tick = 0, m_flag = 0, m_short = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rsq_top i_rsq_top (
        .osc_clk(clk), .por(por), .lvd_det(lvd), .ext_rst_n(ext_n), .stop_req(stop),
        .wake_evt(wake), .short_wake(shrt), .flag_clr(fclr),
        .pin_drive_low(pin), .cpu_rst(cpu), .bus_clk_en(bus), .lvd_flag(flag), .wdog_tick(tick)
    );

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit exp_pin(int ph);              return ph == 0; endfunction
    function automatic bit exp_cpu(int ph, bit extn);    return (ph <= 1) || !extn; endfunction
    function automatic bit exp_bus(int ph);              return !(ph == 3 || ph == 4); endfunction
    function automatic int recover_last(bit s);          return s ? 31 : 4095; endfunction

    // reference model, built from the requirements
    always @(negedge clk) begin
        int old_cnt, old_ph;
        started = 1'b1;
        old_cnt = m_cnt;
        old_ph  = m_ph;
        if (por) begin
            m_cnt = 0; m_tick = 0; m_ph = 0; m_flag = 0; m_short = 0;
        end else begin
            if (lvd) m_flag = 1;
            else if (fclr) m_flag = 0;
            if (lvd) m_ph = 0;
            else case (old_ph)
                0: if (old_cnt == 4095) m_ph = 1;
                1: if (old_cnt == 4159) m_ph = 2;
                2: if (stop) m_ph = 3;
                3: if (wake) begin m_ph = 4; m_short = shrt; end
                4: if (old_cnt == recover_last(m_short)) m_ph = 2;
                default: m_ph = 0;
            endcase
            if (lvd || (old_ph == 2 && stop) || old_ph == 3) begin
                m_cnt = 0; m_tick = 0;
            end else begin
                m_tick = (old_cnt == 8191);
                m_cnt  = (old_cnt + 1) % 8192;
            end
        end
    end

    // cycle-by-cycle comparison against the model
    always @(posedge clk) begin
        if (started && !done) begin
            chk("R3 pin_drive_low", pin,  exp_pin(m_ph));
            chk("R4 cpu_rst",       cpu,  exp_cpu(m_ph, ext_n));
            chk("R8 bus_clk_en",    bus,  exp_bus(m_ph));
            chk("R6 lvd_flag",      flag, m_flag);
            chk("R1 wdog_tick",     tick, m_tick);
        end
    end

    task automatic drive_next();
        @(posedge clk); #2;
    endtask

    // count falling edges until a sampled signal reaches a level
    task automatic edges_until(ref logic sig, input logic lvl, output int n);
        n = 0;
        do begin
            @(negedge clk); #1; n++;
        end while (sig !== lvl && n < 20000);
    endtask

    task automatic wait_run();
        while (m_ph != 2) @(posedge clk);
    endtask

    initial begin : main
        int n;
        void'($urandom(32'd2718));
        repeat (4) @(posedge clk);
        chk("R2 reset pin",  pin,  1);
        chk("R2 reset cpu",  cpu,  1);
        chk("R2 reset bus",  bus,  1);
        chk("R2 reset flag", flag, 0);
        chk("R2 reset tick", tick, 0);
        @(posedge clk); #2; por = 1'b0;
        edges_until(pin, 1'b0, n);
        chk("R3 pin hold length", n, 4096);
        edges_until(cpu, 1'b0, n);
        chk("R4 cpu hold extra", n, 64);

        // R9: tick spacing unchanged across an external reset
        while (tick !== 1'b1) @(posedge clk);
        n = 0;
        do begin
            @(negedge clk); #1; n++;
            if (n == 1000) ext_n = 1'b0;
            if (n == 1050) chk("R9 ext reset reaches cpu", cpu, 1);
            if (n == 1100) ext_n = 1'b1;
        end while (tick !== 1'b1 && n < 20000);
        chk("R9 R1 tick period", n, 8192);

        // R8: short then long recovery
        for (int k = 0; k < 2; k++) begin
            drive_next(); stop = 1'b1;
            @(negedge clk); #1; stop = 1'b0;
            chk("R7 stop drops bus", bus, 0);
            repeat (5) drive_next();
            wake = 1'b1; shrt = (k == 0);
            @(negedge clk); #1; wake = 1'b0; shrt = ~shrt;
            edges_until(bus, 1'b1, n);
            chk("R8 recovery length", n, (k == 0) ? 32 : 4096);
        end

        // random phase with occasional events
        for (int i = 0; i < 50000; i++) begin
            drive_next();
            lvd   = ($urandom % 4000) == 0;
            stop  = ($urandom % 400) == 0;
            wake  = (m_ph == 3) && (($urandom % 40) == 0);
            shrt  = $urandom % 2;
            ext_n = ($urandom % 200) != 0;
            fclr  = ($urandom % 900) == 0;
        end
        drive_next();
        lvd = 0; stop = 0; wake = 0; ext_n = 1; fclr = 0;

        // R7: stop ignored during the reset sequence
        por = 1'b1; drive_next(); por = 1'b0;
        while (!(m_ph == 1)) @(posedge clk);
        #2; stop = 1'b1;
        @(negedge clk); #1; stop = 1'b0;
        chk("R7 stop ignored in reset", bus, 1);
        chk("R7 cpu still held", cpu, 1);

        // R10: stop lands on the wrap edge
        wait_run();
        while (m_cnt != 8191) @(posedge clk);
        #2; stop = 1'b1;
        @(negedge clk); #1; stop = 1'b0;
        chk("R10 no tick on clear", tick, 0);
        chk("R10 bus off", bus, 0);

        // R11: lvd together with wake while stopped
        drive_next(); lvd = 1'b1; wake = 1'b1; shrt = 1'b1;
        @(negedge clk); #1; wake = 1'b0;
        chk("R11 pin driven", pin, 1);
        chk("R5 flag set", flag, 1);
        repeat (9) @(negedge clk);
        #1; lvd = 1'b0;
        edges_until(pin, 1'b0, n);
        chk("R5 held lvd restarts sequence", n, 4096);

        // R6: flag persistence and clear priority
        repeat (100) @(posedge clk);
        chk("R6 flag persists", flag, 1);
        drive_next(); fclr = 1'b1; lvd = 1'b1;
        @(negedge clk); #1; lvd = 1'b0;
        chk("R6 set wins over clear", flag, 1);
        @(negedge clk); #1; fclr = 1'b0;
        chk("R6 flag cleared", flag, 0);

        repeat (5) @(posedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        done = 1'b1;
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule